// File: doc/BRIEF.md
# SDRAM Read Sequencer with Open-Row Tracking

This block accepts read requests from an on-chip bus and turns each one into the command sequence an SDRAM device needs. The device has a single rank of four banks and a 32-bit data bus. The block remembers which row is open in every bank. A request that lands in an open row goes straight to column reads. A request that needs a different row first closes the open row, then opens the new one. Two programmable gaps are inserted: one between closing and opening a row, and one between opening a row and the first column read. Read data is taken from the device a programmable CAS latency after each column read and is handed back to the bus with a valid strobe and a last-beat flag.

Requests come in two kinds. A single-word request acts as one step of an incrementing stream of unknown length. After it, the block reads the following column ahead of time and keeps that word in a one-entry buffer. If the next request asks for exactly that column, it is served from the buffer without waiting for the CAS latency. If it asks for anything else, the buffered word is dropped and the row stays open. Fixed bursts of 4, 8 or 16 words are read as back-to-back columns with no read-ahead. A fixed burst ends early at the last column of the row, or when the bus signals that it has stalled. After a stall, the block falls back to the incrementing behaviour.

Top module: `sdr_rd_ctrl`

## Requirements
- R1: Commands on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} are encoded as follows: NOP = 0111, ACTIVATE = 0011, READ = 0101, PRECHARGE = 0010. No other code ever appears. The address pins carry the row with ACTIVATE and the column, zero-extended, with READ. Out of reset the command is NOP, req_ready is 1 and rd_valid is 0.
- R2: A request whose bank holds the requested row open is served with READ commands only, with no PRECHARGE and no ACTIVATE. req_addr is laid out as {bank, row, column}, with the column in the low COL_W bits.
- R3: A request to a bank whose open row differs issues PRECHARGE to that bank, then ACTIVATE of the new row, then READ. PRECHARGE is never sent to a closed bank, and ACTIVATE is never sent to an open bank.
- R4: Reset closes all banks. The first request to any bank after reset issues ACTIVATE without PRECHARGE.
- R5: ACTIVATE appears exactly max(cfg_trp,1) cycles after the PRECHARGE to that bank. The cycles in between carry NOP.
- R6: The first READ after an ACTIVATE appears exactly max(cfg_trcd,1) cycles after it. The cycles in between carry NOP.
- R7: The data word for a READ issued in cycle k is taken from sd_dq in cycle k+cfg_cl (cfg_cl is 1, 2 or 3). Words reach rd_data in request order, one rd_valid cycle per word, and the returned word belongs to the requested bank, row and column.
- R8: A single-word request (req_len = 0) returns one word with rd_last set. It is followed by a read-ahead READ of the next column unless the column is the last of the row. A following single-word request for that next column issues no READ for it.
- R9: When the next request does not take the read-ahead word, the word is never returned, and the open row stays valid: a later request to that row issues no PRECHARGE or ACTIVATE.
- R10: req_len codes 1, 2 and 3 request fixed bursts of 4, 8 and 16 words. These issue one READ per cycle on consecutive columns, set rd_last on the final word only, and issue no read-ahead READ.
- R11: A fixed burst that reaches the last column of the row stops after that column and sets rd_last on it.
- R12: If bus_hold is high in a cycle where a fixed burst issues a READ (other than its final one), that READ ends the burst with rd_last, and the next column is then read ahead as for a single-word request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trp | input | CFG_W | Cycles from PRECHARGE to ACTIVATE (0 acts as 1) |
| cfg_trcd | input | CFG_W | Cycles from ACTIVATE to first READ (0 acts as 1) |
| cfg_cl | input | 2 | CAS latency, 1 to 3 (0 acts as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | BANK_W+ROW_W+COL_W | Word address {bank, row, column} |
| req_len | input | 2 | 0 single/incrementing, 1 = 4, 2 = 8, 3 = 16 words |
| bus_hold | input | 1 | Bus stalled; breaks a fixed burst |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BANK_W | SDRAM bank select |
| sd_addr | output | ROW_W | SDRAM row or column address |
| sd_dq | input | DATA_W | SDRAM read data |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | DATA_W | Read word |
| rd_last | output | 1 | Final word of the request |

## Verification
A stale entry in the open-row table shows up on the command pins before any data moves. Either a PRECHARGE or ACTIVATE appears that should not, or it is missing and a READ reaches a bank whose row the memory model does not consider open. Both are caught in the cycle the command appears. A wrong latency slot, or a read-ahead word that was not dropped, shows up as a wrong or extra word on rd_data. This is caught on the first rd_valid cycle after the fault, at most four cycles after the offending READ. Gap counters that are off by one are seen directly as the distance between PRECHARGE, ACTIVATE and READ on the pins.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_PRE = 4'b0010
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_TRP, S_ACT, S_TRCD, S_RD, S_SPEC, S_BUF
  } seq_state_e;

  // tag travelling with a READ until its data is sampled
  typedef struct packed {
    logic vld;
    logic last;
    logic spec;
    logic gen;
  } rd_tag_t;

  // a programmed gap of zero behaves as one cycle
  function automatic logic [7:0] gap_cycles(input logic [7:0] cfg);
    return (cfg == 8'd0) ? 8'd1 : cfg;
  endfunction

  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      2'd3:    return 5'd16;
      default: return 5'd1;
    endcase
  endfunction

  function automatic logic [1:0] cas_slots(input logic [1:0] cl);
    return (cl == 2'd0) ? 2'd1 : cl;
  endfunction

endpackage

// File: rtl/sdr_open_rows.sv
module sdr_open_rows #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_open,
  output logic              lk_hit,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row
);
  localparam int BANKS = 1 << BANK_W;

  logic [BANKS-1:0] vld_q;
  logic [ROW_W-1:0] row_q [BANKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int b = 0; b < BANKS; b++) row_q[b] <= '0;
    end else if (upd_en) begin
      vld_q[upd_bank] <= 1'b1;
      row_q[upd_bank] <= upd_row;
    end
  end

  assign lk_open = vld_q[lk_bank];
  assign lk_hit  = lk_open && (row_q[lk_bank] == lk_row);

endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe
  import sdr_rd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  rd_tag_t           ins_tag,
  input  logic [1:0]        cfg_cl,
  input  logic [DATA_W-1:0] sd_dq,
  output logic              cap_vld,
  output logic              cap_last,
  output logic              cap_spec,
  output logic              cap_gen,
  output logic [DATA_W-1:0] cap_data
);
  localparam int IDX_W = $clog2(MAX_CL + 1);

  rd_tag_t           slot_q [MAX_CL+1];
  logic [IDX_W-1:0]  ins_idx;

  assign ins_idx = IDX_W'(cas_slots(cfg_cl));

  // slot MAX_CL..0 moves one step per cycle; slot 0 marks the sampling cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= MAX_CL; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < MAX_CL; i++) slot_q[i] <= slot_q[i+1];
      slot_q[MAX_CL] <= '0;
      if (ins_en) slot_q[ins_idx] <= ins_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld  <= 1'b0;
      cap_last <= 1'b0;
      cap_spec <= 1'b0;
      cap_gen  <= 1'b0;
      cap_data <= '0;
    end else begin
      cap_vld  <= slot_q[0].vld;
      cap_last <= slot_q[0].last;
      cap_spec <= slot_q[0].spec;
      cap_gen  <= slot_q[0].gen;
      if (slot_q[0].vld) cap_data <= sd_dq;
    end
  end

endmodule

// File: rtl/sdr_rd_ctrl.sv
module sdr_rd_ctrl
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CFG_W-1:0]              cfg_trp,
  input  logic [CFG_W-1:0]              cfg_trcd,
  input  logic [1:0]                    cfg_cl,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [1:0]                    req_len,
  input  logic                          bus_hold,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  input  logic [DATA_W-1:0]             sd_dq,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_last
);
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;

  seq_state_e        state_q;
  sdr_cmd_e          cmd_q;
  logic [BANK_W-1:0] ba_q, cur_bank;
  logic [ROW_W-1:0]  addr_q, cur_row;
  logic [COL_W-1:0]  cur_col;
  logic [4:0]        left_q;
  logic              fixed_q;
  logic [CFG_W-1:0]  cnt_q;
  logic              spec_live_q, spec_full_q, gen_q;
  logic [ADDR_W-1:0] spec_addr_q;
  logic [DATA_W-1:0] spec_data_q, buf_data_q;
  logic              buf_rv_q;

  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic              lk_open, lk_hit;
  logic [7:0]        trp_gap, trcd_gap;

  logic              cap_vld, cap_last, cap_spec, cap_gen;
  logic [DATA_W-1:0] cap_data;
  rd_tag_t           ins_tag;

  // named internal events
  logic acc, spec_match, col_last;
  logic ev_pre, ev_act, ev_rd, ev_spec_rd, ev_serve, ev_drop, ev_fill;
  logic rd_end, rd_spec_next;

  assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
  assign req_row  = req_addr[COL_W +: ROW_W];
  assign trp_gap  = gap_cycles(8'(cfg_trp));
  assign trcd_gap = gap_cycles(8'(cfg_trcd));

  assign req_ready  = (state_q == S_IDLE);
  assign acc        = req_valid && req_ready;
  assign spec_match = (req_len == 2'd0) && spec_live_q && (req_addr == spec_addr_q);
  assign col_last   = &cur_col;

  assign ev_pre     = (state_q == S_PRE);
  assign ev_act     = (state_q == S_ACT);
  assign ev_rd      = (state_q == S_RD);
  assign ev_spec_rd = (state_q == S_SPEC);
  assign ev_serve   = (state_q == S_BUF) && spec_full_q;
  assign ev_drop    = acc && !spec_match;
  assign ev_fill    = cap_vld && cap_spec && (cap_gen == gen_q) && spec_live_q;

  // fixed burst finishes on count, row end or a bus stall
  assign rd_end       = ev_rd && (!fixed_q || left_q == 5'd1 || col_last || bus_hold);
  assign rd_spec_next = !col_last && (!fixed_q || (bus_hold && left_q != 5'd1));

  assign ins_tag = '{vld:  1'b1,
                     last: ev_spec_rd ? 1'b1 : rd_end,
                     spec: ev_spec_rd,
                     gen:  ev_spec_rd ? ~gen_q : gen_q};

  sdr_open_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) i_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_bank  (req_bank),
    .lk_row   (req_row),
    .lk_open  (lk_open),
    .lk_hit   (lk_hit),
    .upd_en   (ev_act),
    .upd_bank (cur_bank),
    .upd_row  (cur_row)
  );

  sdr_lat_pipe #(.DATA_W(DATA_W), .MAX_CL(3)) i_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_en   (ev_rd || ev_spec_rd),
    .ins_tag  (ins_tag),
    .cfg_cl   (cfg_cl),
    .sd_dq    (sd_dq),
    .cap_vld  (cap_vld),
    .cap_last (cap_last),
    .cap_spec (cap_spec),
    .cap_gen  (cap_gen),
    .cap_data (cap_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cmd_q       <= CMD_NOP;
      ba_q        <= '0;
      addr_q      <= '0;
      cur_bank    <= '0;
      cur_row     <= '0;
      cur_col     <= '0;
      left_q      <= '0;
      fixed_q     <= 1'b0;
      cnt_q       <= '0;
      spec_live_q <= 1'b0;
      spec_full_q <= 1'b0;
      gen_q       <= 1'b0;
      spec_addr_q <= '0;
      spec_data_q <= '0;
      buf_data_q  <= '0;
      buf_rv_q    <= 1'b0;
    end else begin
      cmd_q    <= CMD_NOP;
      buf_rv_q <= 1'b0;
      if (ev_fill) begin
        spec_full_q <= 1'b1;
        spec_data_q <= cap_data;
      end
      if (ev_drop) begin
        spec_live_q <= 1'b0;
        spec_full_q <= 1'b0;
      end
      case (state_q)
        S_IDLE: if (acc) begin
          cur_bank <= req_bank;
          cur_row  <= req_row;
          cur_col  <= req_addr[COL_W-1:0];
          left_q   <= burst_beats(req_len);
          fixed_q  <= (req_len != 2'd0);
          if (spec_match)   state_q <= S_BUF;
          else if (lk_hit)  state_q <= S_RD;
          else if (lk_open) state_q <= S_PRE;
          else              state_q <= S_ACT;
        end
        S_PRE: begin
          cmd_q  <= CMD_PRE;
          ba_q   <= cur_bank;
          addr_q <= '0;
          if (trp_gap == 8'd1) state_q <= S_ACT;
          else begin
            cnt_q   <= CFG_W'(trp_gap - 8'd2);
            state_q <= S_TRP;
          end
        end
        S_TRP: begin
          if (cnt_q == '0) state_q <= S_ACT;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        S_ACT: begin
          cmd_q  <= CMD_ACT;
          ba_q   <= cur_bank;
          addr_q <= cur_row;
          if (trcd_gap == 8'd1) state_q <= S_RD;
          else begin
            cnt_q   <= CFG_W'(trcd_gap - 8'd2);
            state_q <= S_TRCD;
          end
        end
        S_TRCD: begin
          if (cnt_q == '0) state_q <= S_RD;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        S_RD: begin
          cmd_q   <= CMD_RD;
          ba_q    <= cur_bank;
          addr_q  <= ROW_W'(cur_col);
          cur_col <= cur_col + 1'b1;
          left_q  <= left_q - 5'd1;
          if (rd_end) state_q <= rd_spec_next ? S_SPEC : S_IDLE;
        end
        S_SPEC: begin
          cmd_q       <= CMD_RD;
          ba_q        <= cur_bank;
          addr_q      <= ROW_W'(cur_col);
          spec_addr_q <= {cur_bank, cur_row, cur_col};
          spec_live_q <= 1'b1;
          spec_full_q <= 1'b0;
          gen_q       <= ~gen_q;
          state_q     <= S_IDLE;
        end
        S_BUF: if (spec_full_q) begin
          buf_rv_q    <= 1'b1;
          buf_data_q  <= spec_data_q;
          spec_live_q <= 1'b0;
          spec_full_q <= 1'b0;
          cur_col     <= cur_col + 1'b1;
          state_q     <= col_last ? S_IDLE : S_SPEC;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba    = ba_q;
  assign sd_addr  = addr_q;

  assign rd_valid = (cap_vld && !cap_spec) || buf_rv_q;
  assign rd_data  = buf_rv_q ? buf_data_q : cap_data;
  assign rd_last  = buf_rv_q || (cap_vld && !cap_spec && cap_last);

endmodule

// File: rtl/sdr_rd_ctrl_chk.sv
module sdr_rd_ctrl_chk
  import sdr_rd_pkg::*;
#(
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_trp,
  input logic [CFG_W-1:0] cfg_trcd,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rd_valid,
  input logic             rd_last,
  input logic             ev_serve,
  input logic             cap_vld,
  input logic             cap_spec
);
  logic [3:0] pins;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R1: only the four read-path codes appear
  a_r1_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_NOP) || (pins == CMD_ACT) || (pins == CMD_RD) || (pins == CMD_PRE));

  // R5: gap after PRECHARGE
  a_r5_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_PRE) |=> ((cfg_trp <= 1) ? (pins == CMD_ACT) : (pins == CMD_NOP)));

  // R6: gap after ACTIVATE
  a_r6_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_ACT) |=> ((cfg_trcd <= 1) ? (pins == CMD_RD) : (pins == CMD_NOP)));

  // R8: last flag only on a valid word
  a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R2: an accepted request makes the block busy next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7: a buffered word never competes with a sampled word
  a_r7_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
    ev_serve |-> !(cap_vld && !cap_spec));

endmodule

bind sdr_rd_ctrl sdr_rd_ctrl_chk #(.CFG_W(CFG_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_trp   (cfg_trp),
  .cfg_trcd  (cfg_trcd),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .rd_last   (rd_last),
  .ev_serve  (ev_serve),
  .cap_vld   (cap_vld),
  .cap_spec  (cap_spec)
);

// File: tb/test_sdr_rd_ctrl.sv
module test_sdr_rd_ctrl;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 8;
  localparam int DATA_W = 32;
  localparam int CFG_W  = 4;
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CFG_W-1:0]  cfg_trp = 4'd2, cfg_trcd = 4'd3;
  logic [1:0]        cfg_cl = 2'd2;
  logic              req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_len = '0;
  logic              bus_hold = 1'b0;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BANK_W-1:0] sd_ba;
  logic [ROW_W-1:0]  sd_addr;
  logic [DATA_W-1:0] sd_dq = '0;
  logic              rd_valid, rd_last;
  logic [DATA_W-1:0] rd_data;

  always #4 clk = ~clk;

  sdr_rd_ctrl #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CFG_W(CFG_W))
  i_sdr_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_cl(cfg_cl),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .bus_hold(bus_hold), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq(sd_dq),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int b, input int r, input int c);
    return {2'b10, 2'(b), 13'(r), 8'(c), 7'h15};
  endfunction

  function automatic int gap_of(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int beats_of(input int len, input int col, input bit hold);
    int n;
    n = (len == 0) ? 1 : (len == 1) ? 4 : (len == 2) ? 8 : 16;
    if (hold && len != 0) n = 1;
    if (col + n > (1 << COL_W)) n = (1 << COL_W) - col;
    return n;
  endfunction

  // ---------------- memory model and command monitor ----------------
  int n_pre = 0, n_act = 0, n_rd = 0;
  int cyc = 0;
  bit open_vld [4];
  int open_row [4];
  bit pre_flag [4];
  bit first_rd [4];
  int pre_cyc [4];
  int act_cyc [4];
  logic [31:0] ring [8];
  bit ring_v [8];

  always @(posedge clk) begin
    logic [3:0] pins;
    int b;
    cyc++;
    pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    b = int'(sd_ba);
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        open_vld[i] = 0; pre_flag[i] = 0; first_rd[i] = 0;
      end
      for (int i = 0; i < 8; i++) ring_v[i] = 0;
    end else begin
      case (pins)
        4'b0111: ;
        4'b0010: begin
          n_pre++;
          chk(open_vld[b], "R3 precharge to open bank", 32'(open_vld[b]), 32'd1);
          open_vld[b] = 0; pre_flag[b] = 1; pre_cyc[b] = cyc;
        end
        4'b0011: begin
          n_act++;
          chk(!open_vld[b], "R3 activate to closed bank", 32'(open_vld[b]), 32'd0);
          if (pre_flag[b])
            chk(cyc - pre_cyc[b] == gap_of(int'(cfg_trp)), "R5 precharge-activate gap",
                32'(cyc - pre_cyc[b]), 32'(gap_of(int'(cfg_trp))));
          pre_flag[b] = 0; open_vld[b] = 1; open_row[b] = int'(sd_addr);
          act_cyc[b] = cyc; first_rd[b] = 1;
        end
        4'b0101: begin
          n_rd++;
          chk(open_vld[b], "R2 read to open row", 32'(open_vld[b]), 32'd1);
          if (first_rd[b])
            chk(cyc - act_cyc[b] == gap_of(int'(cfg_trcd)), "R6 activate-read gap",
                32'(cyc - act_cyc[b]), 32'(gap_of(int'(cfg_trcd))));
          first_rd[b] = 0;
          ring[(cyc - 1 + int'(cfg_cl)) % 8] = word_of(b, open_row[b], int'(sd_addr[COL_W-1:0]));
          ring_v[(cyc - 1 + int'(cfg_cl)) % 8] = 1;
        end
        default: chk(1'b0, "R1 command code", 32'(pins), 32'h7);
      endcase
    end
    sd_dq <= ring_v[cyc % 8] ? ring[cyc % 8] : 32'h0BAD_F00D;
    ring_v[cyc % 8] = 0;
  end

  // ---------------- scoreboard ----------------
  logic [31:0] exp_d [1024];
  bit          exp_l [1024];
  int wp = 0, rp = 0;

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (wp == rp) chk(1'b0, "R9 unexpected word", rd_data, 32'h0);
      else begin
        chk(rd_data == exp_d[rp % 1024], "R7 read data", rd_data, exp_d[rp % 1024]);
        chk(rd_last == exp_l[rp % 1024], "R10 last flag", 32'(rd_last), 32'(exp_l[rp % 1024]));
        rp++;
      end
    end
  end

  task automatic send(input int b, input int r, input int c, input int len, input bit hold);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {2'(b), 13'(r), 8'(c)};
    req_len   = 2'(len);
    bus_hold  = hold;
    n = beats_of(len, c, hold);
    for (int i = 0; i < n; i++) begin
      exp_d[wp % 1024] = word_of(b, r, c + i);
      exp_l[wp % 1024] = (i == n - 1);
      wp++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!(wp == rp && req_ready)) @(negedge clk);
    repeat (8) @(negedge clk);
    bus_hold = 1'b0;
  endtask

  int s_pre, s_act, s_rd;
  task automatic snap();
    s_pre = n_pre; s_act = n_act; s_rd = n_rd;
  endtask

  task automatic expect_cmds(input string req, input int dp, input int da, input int dr);
    chk(n_pre - s_pre == dp, {req, " precharge count"}, 32'(n_pre - s_pre), 32'(dp));
    chk(n_act - s_act == da, {req, " activate count"}, 32'(n_act - s_act), 32'(da));
    chk(n_rd - s_rd == dr, {req, " read count"}, 32'(n_rd - s_rd), 32'(dr));
  endtask

  task automatic do_reset(input int trp, input int trcd, input int cl);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_trp = 4'(trp); cfg_trcd = 4'(trcd); cfg_cl = 2'(cl);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk(rd_valid == 1'b0, "R1 no data after reset", 32'(rd_valid), 32'd0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP after reset",
        32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
  endtask

  task automatic random_phase(input int count);
    int b, r, c, len;
    b = 0; r = 1; c = 0;
    for (int i = 0; i < count; i++) begin
      if ($urandom % 4 == 0 && c < 255) begin
        c = c + 1; len = 0;
      end else begin
        b = int'($urandom % 4);
        r = 1 + int'($urandom % 3);
        c = int'($urandom % 256);
        len = int'($urandom % 4);
      end
      send(b, r, c, len, 1'b0);
    end
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20517));
    do_reset(2, 3, 2);

    snap(); send(0, 5, 10, 0, 0); wait_idle();
    expect_cmds("R4 first access after reset", 0, 1, 2);

    snap(); send(0, 5, 11, 0, 0); wait_idle();
    expect_cmds("R8 read-ahead hit", 0, 0, 1);

    snap(); send(0, 5, 40, 0, 0); wait_idle();
    expect_cmds("R9 read-ahead dropped, row kept", 0, 0, 2);

    snap(); send(0, 5, 100, 2, 0); wait_idle();
    expect_cmds("R10 fixed 8 on open row (R2)", 0, 0, 8);

    snap(); send(0, 5, 250, 3, 0); wait_idle();
    expect_cmds("R11 burst stops at row end", 0, 0, 6);

    snap(); send(0, 5, 255, 0, 0); wait_idle();
    expect_cmds("R8 no read-ahead past row end", 0, 0, 1);

    snap(); send(0, 9, 0, 1, 0); wait_idle();
    expect_cmds("R3 row change", 1, 1, 4);

    snap(); send(1, 2, 20, 3, 1); wait_idle();
    expect_cmds("R12 stalled burst", 0, 1, 2);
    snap(); send(1, 2, 21, 0, 0); wait_idle();
    expect_cmds("R12 stall continues as incrementing", 0, 0, 1);

    random_phase(150);

    do_reset(1, 1, 1);
    snap(); send(2, 7, 3, 0, 0); wait_idle();
    expect_cmds("R4 banks closed by reset", 0, 1, 2);
    random_phase(150);

    do_reset(4, 2, 3);
    snap(); send(3, 1, 0, 1, 0); send(3, 4, 8, 0, 0); wait_idle();
    expect_cmds("R3 back-to-back row change", 1, 2, 6);
    random_phase(150);

    do_reset(0, 0, 3);
    random_phase(100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule